// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block sits behind an I2C bit-level receiver. It decides whether the address phase of a transfer selects this target. The receiver hands over each completed byte with a one-cycle valid strobe. It also pulses separate inputs when it detects a START (including a repeated START) or a STOP condition. The matcher counts the bytes after each START itself, so it knows which one is the first address byte and which is the second.

Three configuration inputs set the behaviour: a mode bit, a general-call enable and the address fields. With the mode bit clear, the target answers to a 7-bit address. With it set, the target answers to a 10-bit address taken from a 3-bit upper field joined to the 7-bit lower field. In that mode the address arrives as a header byte followed by a second byte. The matcher remembers a successful 10-bit write addressing. A later repeated START carrying the same header with the read bit set is then accepted on its first byte. When enabled, the all-zero general-call byte is also accepted.

The outputs are registered. They are a one-cycle match pulse, a general-call flag and the transfer direction. The flag and the direction hold until the next START or STOP.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, match_pulse, gcall and rw_dir are 0, and with all configuration inputs at 0 a first byte of 0x00 produces no match.
- R2: With cfg_ext=0, a first byte after START whose bits 7..1 equal cfg_addr_lo raises match_pulse for exactly one cycle, in the cycle after the byte strobe, and rw_dir takes byte bit 0 (1 = read).
- R3: In 7-bit mode a non-matching first byte gives no pulse, and bytes after the first one of a transfer never give a pulse.
- R4: A first byte of 0x00 matches as a general call only when cfg_gc_en=1, setting gcall=1 with the pulse and rw_dir=0; gcall holds until the next START or STOP, and 0x01 is never a general call.
- R5: With cfg_ext=1, the first byte 11110, A9, A8, 0 (A9..A8 = cfg_addr_hi[2:1]) gives no pulse; a following second byte equal to {cfg_addr_hi[0], cfg_addr_lo} gives the pulse with rw_dir=0; a wrong header puts the matcher out of the address phase.
- R6: A second byte that does not match gives no pulse and drops the remembered 10-bit addressing, so a later repeated START read does not match.
- R7: After a complete 10-bit write match, a repeated START followed by the header with bit 0 = 1 pulses on that first byte with rw_dir=1; without that earlier match the same byte gives no pulse.
- R8: A STOP clears gcall, rw_dir and the remembered 10-bit addressing.
- R9: In 10-bit mode a byte that would be a 7-bit match gives no pulse; in 7-bit mode cfg_addr_hi has no effect.
- R10: A byte strobe in the same cycle as a START is dropped, and the next byte is treated as the first byte.
- R11: A first byte whose bits 7..1 are zero never matches the programmed address, even when cfg_addr_lo is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_start | input | 1 | One-cycle pulse on START or repeated START |
| bus_stop | input | 1 | One-cycle pulse on STOP |
| byte_vld | input | 1 | One-cycle strobe: byte_data holds a complete received byte |
| byte_data | input | 8 | Received byte, bit 7 first on the wire |
| cfg_ext | input | 1 | 0 = 7-bit scheme, 1 = 10-bit scheme |
| cfg_gc_en | input | 1 | Accept the general-call byte |
| cfg_addr_lo | input | 7 | Address bits 6..0 (7-bit) or bits 6..0 of the 10-bit address |
| cfg_addr_hi | input | 3 | Address bits 9..7 of the 10-bit address; unused in 7-bit mode |
| match_pulse | output | 1 | One-cycle pulse when this target is addressed |
| gcall | output | 1 | The current match is a general call |
| rw_dir | output | 1 | Direction of the addressed transfer, 1 = read |

## Verification
The only state behind the ports is the byte phase and the remembered 10-bit addressing. If either one is wrong, the error shows as a missing or extra match pulse one cycle after the byte that should have decided the match. A phase stuck at the first byte, for example, shows as pulses on data bytes. A stale remembered addressing shows only later, on the first byte after the next repeated START. The bench therefore runs full START, header, second byte, repeated START sequences, and STOP-separated ones, and checks each pulse at its exact cycle.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_FIRST  = 2'd1,
      PH_SECOND = 2'd2
   } phase_e;

   typedef struct packed {
      logic gc_code;
      logic own7;
      logic hdr;
      logic low8;
   } cmp_hits_t;
endpackage

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp
   import i2c_am_pkg::*;
#(
   parameter int          BYTE_W    = 8,
   parameter int          LO_W      = 7,
   parameter int          HI_W      = 3,
   parameter bit          TENBIT_EN = 1'b1,
   parameter logic [7:0]  GC_CODE   = 8'h00,
   parameter logic [4:0]  HDR_PFX   = 5'b11110
)(
   input  logic [BYTE_W-1:0] byte_data,
   input  logic [LO_W-1:0]   cfg_addr_lo,
   input  logic [HI_W-1:0]   cfg_addr_hi,
   output cmp_hits_t         hits
);
   localparam int PFX_W = BYTE_W - HI_W;

   logic [LO_W-1:0] addr_field;
   assign addr_field = byte_data[BYTE_W-1:1];

   always_comb begin
      hits.gc_code = (byte_data == GC_CODE[BYTE_W-1:0]);
      hits.own7    = (addr_field == cfg_addr_lo) && (addr_field != '0);
   end

   generate
      if (TENBIT_EN) begin : g_ten
         logic [HI_W-2:0] hdr_hi;
         assign hdr_hi = cfg_addr_hi[HI_W-1:1];
         always_comb begin
            hits.hdr  = (byte_data[BYTE_W-1:HI_W] == HDR_PFX[PFX_W-1:0])
                        && (byte_data[HI_W-1:1] == hdr_hi);
            hits.low8 = (byte_data == {cfg_addr_hi[0], cfg_addr_lo});
         end
      end else begin : g_seven
         always_comb begin
            hits.hdr  = 1'b0;
            hits.low8 = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/i2c_am_seq.sv
module i2c_am_seq
   import i2c_am_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   bus_start,
   input  logic   bus_stop,
   input  logic   byte_vld,
   input  logic   go_second,
   output phase_e phase
);
   phase_e phase_q;
   assign phase = phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
      end else if (bus_stop) begin
         phase_q <= PH_IDLE;
      end else if (bus_start) begin
         phase_q <= PH_FIRST;
      end else if (byte_vld) begin
         case (phase_q)
            PH_FIRST:  phase_q <= go_second ? PH_SECOND : PH_IDLE;
            default:   phase_q <= PH_IDLE;
         endcase
      end
   end

   p_second_follows_hdr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_SECOND) |-> $past(go_second) || $past(phase_q == PH_SECOND));
   p_start_arms_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bus_start) && !$past(bus_stop)) |-> (phase_q == PH_FIRST));
endmodule

// File: rtl/i2c_am_resp.sv
module i2c_am_resp
   import i2c_am_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      bus_start,
   input  logic      bus_stop,
   input  logic      byte_vld,
   input  logic      byte_rw,
   input  phase_e    phase,
   input  logic      ext_mode,
   input  logic      cfg_gc_en,
   input  cmp_hits_t hits,
   output logic      go_second,
   output logic      match_pulse,
   output logic      gcall,
   output logic      rw_dir
);
   logic take, first_b, second_b;
   logic gc_hit, seven_hit, hdr_rd_hit, sec_hit, any_hit;
   logic addressed_q, pulse_q, gcall_q, rw_q;

   always_comb begin
      take       = byte_vld && !bus_start && !bus_stop;
      first_b    = take && (phase == PH_FIRST);
      second_b   = take && (phase == PH_SECOND);
      gc_hit     = first_b && cfg_gc_en && hits.gc_code;
      seven_hit  = first_b && !ext_mode && hits.own7;
      go_second  = first_b && ext_mode && hits.hdr && !byte_rw;
      hdr_rd_hit = first_b && ext_mode && hits.hdr && byte_rw && addressed_q;
      sec_hit    = second_b && hits.low8;
      any_hit    = gc_hit || seven_hit || hdr_rd_hit || sec_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addressed_q <= 1'b0;
         pulse_q     <= 1'b0;
         gcall_q     <= 1'b0;
         rw_q        <= 1'b0;
      end else begin
         pulse_q <= any_hit;
         if (bus_stop) begin
            addressed_q <= 1'b0;
         end else if (sec_hit) begin
            addressed_q <= 1'b1;
         end else if (second_b || (first_b && !hdr_rd_hit)) begin
            addressed_q <= 1'b0;
         end
         if (bus_start || bus_stop) begin
            gcall_q <= 1'b0;
            rw_q    <= 1'b0;
         end else if (any_hit) begin
            gcall_q <= gc_hit;
            rw_q    <= hdr_rd_hit || (seven_hit && byte_rw);
         end
      end
   end

   assign match_pulse = pulse_q;
   assign gcall       = gcall_q;
   assign rw_dir      = rw_q;

   p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse |=> !match_pulse);
   p_gc_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gcall) |-> $past(cfg_gc_en) && $past(hits.gc_code) && match_pulse);
   p_gc_is_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      gcall |-> !rw_dir);
   p_read_needs_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (match_pulse && rw_dir && $past(ext_mode)) |-> $past(addressed_q));
   p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_stop) |-> !gcall && !rw_dir && !match_pulse && !addressed_q);
   p_start_drops_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_start) |-> !match_pulse);
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
   import i2c_am_pkg::*;
#(
   parameter int          BYTE_W    = 8,
   parameter int          LO_W      = 7,
   parameter int          HI_W      = 3,
   parameter bit          TENBIT_EN = 1'b1,
   parameter logic [7:0]  GC_CODE   = 8'h00,
   parameter logic [4:0]  HDR_PFX   = 5'b11110
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_start,
   input  logic              bus_stop,
   input  logic              byte_vld,
   input  logic [BYTE_W-1:0] byte_data,
   input  logic              cfg_ext,
   input  logic              cfg_gc_en,
   input  logic [LO_W-1:0]   cfg_addr_lo,
   input  logic [HI_W-1:0]   cfg_addr_hi,
   output logic              match_pulse,
   output logic              gcall,
   output logic              rw_dir
);
   localparam int PFX_W = BYTE_W - HI_W;

   generate
      if (LO_W + 1 != BYTE_W) begin : g_bad_lo
         $error("i2c_addr_match: LO_W must be BYTE_W-1");
      end
      if (HI_W != 3) begin : g_bad_hi
         $error("i2c_addr_match: HI_W must be 3");
      end
      if (PFX_W != 5) begin : g_bad_pfx
         $error("i2c_addr_match: header prefix must be 5 bits");
      end
   endgenerate

   logic      ext_mode;
   logic      go_second;
   phase_e    phase;
   cmp_hits_t hits;

   generate
      if (TENBIT_EN) begin : g_ext_on
         assign ext_mode = cfg_ext;
      end else begin : g_ext_off
         assign ext_mode = 1'b0;
      end
   endgenerate

   i2c_am_cmp #(
      .BYTE_W(BYTE_W), .LO_W(LO_W), .HI_W(HI_W),
      .TENBIT_EN(TENBIT_EN), .GC_CODE(GC_CODE), .HDR_PFX(HDR_PFX)
   ) u_cmp (
      .byte_data  (byte_data),
      .cfg_addr_lo(cfg_addr_lo),
      .cfg_addr_hi(cfg_addr_hi),
      .hits       (hits)
   );

   i2c_am_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_start(bus_start),
      .bus_stop (bus_stop),
      .byte_vld (byte_vld),
      .go_second(go_second),
      .phase    (phase)
   );

   i2c_am_resp u_resp (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_start  (bus_start),
      .bus_stop   (bus_stop),
      .byte_vld   (byte_vld),
      .byte_rw    (byte_data[0]),
      .phase      (phase),
      .ext_mode   (ext_mode),
      .cfg_gc_en  (cfg_gc_en),
      .hits       (hits),
      .go_second  (go_second),
      .match_pulse(match_pulse),
      .gcall      (gcall),
      .rw_dir     (rw_dir)
   );

   p_ext_off_no_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (match_pulse && !$past(ext_mode) && !gcall) |-> $past(byte_vld));
endmodule

// File: tb/i2c_addr_match_bench.sv
module i2c_addr_match_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_start = 1'b0, bus_stop = 1'b0, byte_vld = 1'b0;
   logic [7:0] byte_data = 8'h00;
   logic       cfg_ext = 1'b0, cfg_gc_en = 1'b0;
   logic [6:0] cfg_addr_lo = 7'h00;
   logic [2:0] cfg_addr_hi = 3'h0;
   logic       match_pulse, gcall, rw_dir;
   int         n_chk = 0, n_err = 0;

   always #2 clk = ~clk;

   i2c_addr_match u_i2c_addr_match (
      .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
      .byte_vld(byte_vld), .byte_data(byte_data), .cfg_ext(cfg_ext),
      .cfg_gc_en(cfg_gc_en), .cfg_addr_lo(cfg_addr_lo), .cfg_addr_hi(cfg_addr_hi),
      .match_pulse(match_pulse), .gcall(gcall), .rw_dir(rw_dir)
   );

   // {ext, gc_en, hi[2:0], lo[6:0], byte[7:0], exp_match, exp_gcall, exp_rw}
   localparam logic [22:0] TBL [0:9] = '{
      {1'b0, 1'b0, 3'h0, 7'h3A, 8'h74, 3'b100},  // R2 write
      {1'b0, 1'b0, 3'h0, 7'h3A, 8'h75, 3'b101},  // R2 read
      {1'b0, 1'b0, 3'h0, 7'h3A, 8'h76, 3'b000},  // R3 mismatch
      {1'b0, 1'b1, 3'h0, 7'h3A, 8'h00, 3'b110},  // R4 gc enabled
      {1'b0, 1'b0, 3'h0, 7'h3A, 8'h00, 3'b000},  // R4 gc disabled
      {1'b0, 1'b1, 3'h0, 7'h3A, 8'h01, 3'b000},  // R4 0x01 is not gc
      {1'b0, 1'b0, 3'h5, 7'h3A, 8'h74, 3'b100},  // R9 hi ignored in 7-bit
      {1'b1, 1'b0, 3'h0, 7'h3A, 8'h74, 3'b000},  // R9 7-bit byte in 10-bit mode
      {1'b0, 1'b0, 3'h0, 7'h00, 8'h00, 3'b000},  // R11 zero address
      {1'b0, 1'b0, 3'h0, 7'h00, 8'h01, 3'b000}   // R11 zero address read
   };

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic start_c();
      @(negedge clk); bus_start = 1'b1;
      @(negedge clk); bus_start = 1'b0;
   endtask

   task automatic stop_c();
      @(negedge clk); bus_stop = 1'b1;
      @(negedge clk); bus_stop = 1'b0;
   endtask

   // Strobe a byte; returns at the negedge after the capturing edge.
   task automatic send(input logic [7:0] b);
      @(negedge clk); byte_vld = 1'b1; byte_data = b;
      @(negedge clk); byte_vld = 1'b0;
   endtask

   initial begin
      #400000;
      n_chk++; n_err++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset match_pulse", match_pulse, 1'b0);
      chk("R1 reset gcall", gcall, 1'b0);
      chk("R1 reset rw_dir", rw_dir, 1'b0);
      start_c(); send(8'h00);
      chk("R1 default no gc", match_pulse, 1'b0);

      for (int i = 0; i < 10; i++) begin
         {cfg_ext, cfg_gc_en, cfg_addr_hi, cfg_addr_lo} = TBL[i][22:11];
         start_c(); send(TBL[i][10:3]);
         chk($sformatf("vec%0d match", i), match_pulse, TBL[i][2]);
         chk($sformatf("vec%0d gcall", i), gcall, TBL[i][1]);
         chk($sformatf("vec%0d rw", i), rw_dir, TBL[i][0]);
      end

      // R2 pulse lasts one cycle; R3 later bytes ignored
      cfg_ext = 1'b0; cfg_gc_en = 1'b0; cfg_addr_lo = 7'h3A; cfg_addr_hi = 3'h0;
      start_c(); send(8'h74);
      chk("R2 pulse", match_pulse, 1'b1);
      @(negedge clk);
      chk("R2 one cycle", match_pulse, 1'b0);
      send(8'h74);
      chk("R3 data byte no pulse", match_pulse, 1'b0);

      // R4 gcall holds, cleared by START
      cfg_gc_en = 1'b1;
      start_c(); send(8'h00);
      repeat (2) @(negedge clk);
      chk("R4 gcall held", gcall, 1'b1);
      start_c();
      chk("R4 gcall cleared by start", gcall, 1'b0);
      cfg_gc_en = 1'b0;

      // R10 byte with START dropped, next byte is first
      @(negedge clk); bus_start = 1'b1; byte_vld = 1'b1; byte_data = 8'h74;
      @(negedge clk); bus_start = 1'b0; byte_vld = 1'b0;
      chk("R10 dropped", match_pulse, 1'b0);
      send(8'h74);
      chk("R10 next is first", match_pulse, 1'b1);

      // 10-bit: A = {110, 0101011}; header W=0xF6, R=0xF7, low8=0x2B
      cfg_ext = 1'b1; cfg_addr_hi = 3'b110; cfg_addr_lo = 7'h2B;
      stop_c();
      start_c(); send(8'hF7);
      chk("R7 read without prior match", match_pulse, 1'b0);
      start_c(); send(8'hF6);
      chk("R5 header no pulse", match_pulse, 1'b0);
      send(8'h2B);
      chk("R5 second byte pulse", match_pulse, 1'b1);
      chk("R5 rw write", rw_dir, 1'b0);
      start_c(); send(8'hF7);
      chk("R7 repeated start read", match_pulse, 1'b1);
      chk("R7 rw read", rw_dir, 1'b1);
      stop_c();
      chk("R8 rw cleared", rw_dir, 1'b0);
      start_c(); send(8'hF7);
      chk("R8 addressing cleared", match_pulse, 1'b0);

      // R6 second byte mismatch
      start_c(); send(8'hF6); send(8'h2C);
      chk("R6 mismatch no pulse", match_pulse, 1'b0);
      start_c(); send(8'hF7);
      chk("R6 no read after mismatch", match_pulse, 1'b0);

      // R5 wrong header bits 9..8
      start_c(); send(8'hF4); send(8'h2B);
      chk("R5 wrong header", match_pulse, 1'b0);

      // R8 gcall cleared by STOP
      cfg_ext = 1'b0; cfg_gc_en = 1'b1;
      start_c(); send(8'h00);
      chk("R4 gc pulse", gcall, 1'b1);
      stop_c();
      chk("R8 gcall cleared", gcall, 1'b0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule